// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block is the on-chip controller that walks a programmable fabric from power-up through reset, configuration and initialisation into user mode. Software talks to it through a small register slave. One word holds the control settings and one reports status. The status word gives the current phase, the sampled mode-select pins and the width and clock ratio those pins call for. Software copies the suggested width and ratio into the control word, then pulls the fabric's configuration request low and releases it. Once configuration is under way, it streams configuration words through a data address.

The sequencer does not advance on a timer. It moves only in response to the pull-low and enable settings and to the fabric's done and status inputs. A good load is seen as done and status both high. After a fixed number of trailing clock cycles in the initialisation phase, the sequencer enters user mode. A failed load, seen as done and status both low, sends the sequencer back to reset and raises a sticky error. The error holds the sequencer in reset until software pulls the request low again. Data words are forwarded to the fabric only while transfer is enabled. In the narrow setting the upper half of each word is cleared.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x0000_0002 (chip enable inactive), the status phase field reads 0, the error bit is 0, `cfg_req_n` and `chip_en_n` are 1 and `data_strobe` is 0.
- R2: Phase codes are 0 power-up, 1 reset, 2 configuration, 3 initialisation, 4 user, 5 unknown, in status bits [2:0]. With control bit 0 (enable) and bit 2 (pull-low) both set, `cfg_req_n` is low in the same cycle the control word holds them, and the phase reads 1 one clock later, from any phase.
- R3: In phase 1 with no error, enable set and pull-low clear, the phase reads 2 one clock later.
- R4: In phase 2, `fab_done` and `fab_status` both high move the phase to 3 on the next clock. The phase then reads 4 exactly DONE_CYCLES (default 4) clocks later and stays there.
- R5: In phase 2, `fab_done` and `fab_status` both low move the phase to 1 and set the error bit (status bit 9). While the error is set the phase stays 1 even with pull-low clear. The next enabled pull-low clears the error one clock after the control write.
- R6: The mode-select pins are sampled each clock into status bits [7:3]. Status bit 8 is set when the sampled code is unsupported. The supported codes are 0-2, 4-6, 8-10 and 12-14.
- R7: For a supported code, status bit 12 is 1 for codes 8-14 (32-bit) and 0 for codes 0-6 (16-bit). Status bits [11:10] give the log2 ratio: 0 when code mod 4 is 0, 1 (narrow) or 2 (wide) when it is 1, and 2 (narrow) or 3 (wide) when it is 2. For an unsupported code bits [12:10] are 0.
- R8: A write to address 2 is placed on `data_word` with `data_strobe` high on the next clock only if control bit 0 (enable) and bit 8 (transfer) are set. Otherwise no strobe appears.
- R9: With control bit 9 clear, a forwarded word has bits [31:16] cleared. With bit 9 set, it passes whole.
- R10: With control bit 0 clear, `cfg_req_n` and `chip_en_n` stay 1, pull-low has no effect on the phase, and data writes produce no strobe.
- R11: While `power_good` is low the status phase field reads 0. The sequencer keeps its phase, which reads again once `power_good` returns.
- R12: The control word keeps only bits 0,1,2,6,7,8,9. Bits [7:6] drive `clk_ratio` and bit 9 drives `wide_bus`. While enabled, bit 1 drives `chip_en_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 2 | Write address: 0 control, 2 data |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 2 | Read address: 0 control, 1 status |
| bus_rdata | output | 32 | Read data, combinational |
| msel_pins | input | 5 | Mode-select pins |
| power_good | input | 1 | Fabric supplies good |
| fab_done | input | 1 | Fabric configuration done |
| fab_status | input | 1 | Fabric status, high when healthy |
| cfg_req_n | output | 1 | Active-low configuration request |
| chip_en_n | output | 1 | Active-low chip enable |
| clk_ratio | output | 2 | Clock-to-data ratio, log2 |
| wide_bus | output | 1 | 32-bit data width selected |
| data_word | output | 32 | Configuration word to the fabric |
| data_strobe | output | 1 | `data_word` valid for one cycle |

## Verification
Control-word effects on `cfg_req_n`, `chip_en_n`, `clk_ratio` and `wide_bus` are due in the cycle the write lands. Phase changes are due one clock after the control write or after the done and status inputs change. The user phase is due DONE_CYCLES clocks after the initialisation phase appears. Sampled mode-select pins and forwarded data words are due one clock after they are applied. The bench drives on the falling edge and samples on the following falling edge. At that point exactly the registers on the path have clocked. The bench also checks the phase one clock short of user mode, so an off-by-one count is reported.

// File: rtl/cfgseq_pkg.sv
`timescale 1ns/1ps
package cfgseq_pkg;

  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int MSEL_W  = 5;
  localparam int ADDR_W  = 2;

  typedef enum logic [2:0] {
    MD_PWRUP   = 3'd0,
    MD_RESET   = 3'd1,
    MD_CONFIG  = 3'd2,
    MD_INIT    = 3'd3,
    MD_USER    = 3'd4,
    MD_UNKNOWN = 3'd5
  } mode_e;

  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_NCE   = 1;
  localparam int CB_PULL  = 2;
  localparam int CB_RLO   = 6;
  localparam int CB_XFER  = 8;
  localparam int CB_WIDE  = 9;

  localparam logic [WORD_W-1:0] CTRL_KEEP  = 32'h0000_03C7;
  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0000_0002;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  function automatic logic msel_ok(input logic [MSEL_W-1:0] m);
    return (m[4] == 1'b0) && (m[1:0] != 2'b11);
  endfunction

  function automatic logic msel_wide(input logic [MSEL_W-1:0] m);
    return msel_ok(m) && m[3];
  endfunction

  // log2 of the clock-to-data ratio the pins call for
  function automatic logic [1:0] msel_ratio(input logic [MSEL_W-1:0] m);
    logic [1:0] r;
    r = 2'd0;
    if (msel_ok(m)) begin
      case (m[1:0])
        2'd1:    r = m[3] ? 2'd2 : 2'd1;
        2'd2:    r = m[3] ? 2'd3 : 2'd2;
        default: r = 2'd0;
      endcase
    end
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] fit_word(input logic [WORD_W-1:0] w,
                                                 input logic wide);
    return wide ? w : {{(WORD_W-HALF_W){1'b0}}, w[HALF_W-1:0]};
  endfunction

endpackage

// File: rtl/cfgseq_regs.sv
`timescale 1ns/1ps
module cfgseq_regs
  import cfgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              data_wr
);

  logic ctrl_wr;

  assign ctrl_wr = bus_we && (bus_addr == A_CTRL);
  assign data_wr = bus_we && (bus_addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_KEEP;
  end

endmodule

// File: rtl/cfgseq_fsm.sv
`timescale 1ns/1ps
module cfgseq_fsm
  import cfgseq_pkg::*;
#(
  parameter int DONE_CYCLES = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  pull,
  input  logic  fab_done,
  input  logic  fab_status,
  output mode_e st,
  output logic  err,
  output logic  pass_evt,
  output logic  fail_evt
);

  localparam int CW = (DONE_CYCLES > 1) ? $clog2(DONE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DONE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign pass_evt = (st == MD_CONFIG) &&  fab_done &&  fab_status;
  assign fail_evt = (st == MD_CONFIG) && !fab_done && !fab_status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= MD_PWRUP;
      err <= 1'b0;
      cnt <= '0;
    end else if (run && pull) begin
      st  <= MD_RESET;
      err <= 1'b0;
      cnt <= '0;
    end else begin
      case (st)
        MD_RESET: if (run && !err) st <= MD_CONFIG;
        MD_CONFIG: begin
          if (pass_evt) begin
            st  <= MD_INIT;
            cnt <= '0;
          end else if (fail_evt) begin
            st  <= MD_RESET;
            err <= 1'b1;
          end
        end
        MD_INIT: begin
          if (cnt == LAST) st <= MD_USER;
          else             cnt <= cnt + 1'b1;
        end
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/cfgseq_data.sv
`timescale 1ns/1ps
module cfgseq_data
  import cfgseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              allow,
  input  logic              wide,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] data_word,
  output logic              data_strobe,
  output logic              accept_evt
);

  assign accept_evt = wr && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_word   <= '0;
      data_strobe <= 1'b0;
    end else begin
      data_strobe <= accept_evt;
      if (accept_evt) data_word <= fit_word(wdata, wide);
    end
  end

endmodule

// File: rtl/cfg_seq_ctrl.sv
`timescale 1ns/1ps
module cfg_seq_ctrl
  import cfgseq_pkg::*;
#(
  parameter int DONE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [MSEL_W-1:0] msel_pins,
  input  logic              power_good,
  input  logic              fab_done,
  input  logic              fab_status,
  output logic              cfg_req_n,
  output logic              chip_en_n,
  output logic [1:0]        clk_ratio,
  output logic              wide_bus,
  output logic [WORD_W-1:0] data_word,
  output logic              data_strobe
);

  localparam int STAT_USED = 3 + MSEL_W + 5;

  logic [WORD_W-1:0] ctrl_q;
  logic [MSEL_W-1:0] msel_q;
  logic              data_wr;
  logic              ctl_en, ctl_pull, ctl_xfer;
  mode_e             st;
  logic              err, pass_evt, fail_evt, accept_evt;
  logic [2:0]        mode_rd;
  logic [WORD_W-1:0] stat_word;

  cfgseq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .data_wr(data_wr)
  );

  assign ctl_en   = ctrl_q[CB_EN];
  assign ctl_pull = ctrl_q[CB_PULL];
  assign ctl_xfer = ctrl_q[CB_XFER];

  cfgseq_fsm #(.DONE_CYCLES(DONE_CYCLES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(ctl_en), .pull(ctl_pull),
    .fab_done(fab_done), .fab_status(fab_status),
    .st(st), .err(err), .pass_evt(pass_evt), .fail_evt(fail_evt)
  );

  cfgseq_data u_data (
    .clk(clk), .rst_n(rst_n), .wr(data_wr), .allow(ctl_en && ctl_xfer),
    .wide(ctrl_q[CB_WIDE]), .wdata(bus_wdata), .data_word(data_word),
    .data_strobe(data_strobe), .accept_evt(accept_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msel_q <= '0;
    else        msel_q <= msel_pins;
  end

  assign mode_rd = power_good ? st : MD_PWRUP;

  assign stat_word = {{(WORD_W-STAT_USED){1'b0}},
                      msel_wide(msel_q), msel_ratio(msel_q), err,
                      !msel_ok(msel_q), msel_q, mode_rd};

  always_comb begin
    case (bus_raddr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = stat_word;
      default: bus_rdata = '0;
    endcase
  end

  assign cfg_req_n = !(ctl_en && ctl_pull);
  assign chip_en_n = ctl_en ? ctrl_q[CB_NCE] : 1'b1;
  assign clk_ratio = ctrl_q[CB_RLO+1:CB_RLO];
  assign wide_bus  = ctrl_q[CB_WIDE];

endmodule

// File: rtl/cfg_seq_ctrl_chk.sv
`timescale 1ns/1ps
module cfg_seq_ctrl_chk
  import cfgseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_en,
  input logic       ctl_pull,
  input logic       ctl_xfer,
  input logic       data_wr,
  input mode_e      st,
  input logic       err,
  input logic       data_strobe,
  input logic       cfg_req_n,
  input logic       chip_en_n,
  input logic       power_good,
  input logic [2:0] mode_rd
);

  a_r2_pull_forces_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && ctl_pull) |=> (st == MD_RESET));

  a_r3_release_to_config: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !ctl_pull && st == MD_RESET && !err) |=> (st == MD_CONFIG));

  a_r4_user_only_from_init: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == MD_USER) && !$stable(st)) |-> ($past(st) == MD_INIT));

  a_r5_error_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (st == MD_RESET));

  a_r8_strobe_needs_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe |-> $past(data_wr && ctl_en && ctl_xfer));

  a_r10_disabled_outputs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> (cfg_req_n && chip_en_n));

  a_r11_no_power_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !power_good |-> (mode_rd == 3'd0));

endmodule

bind cfg_seq_ctrl cfg_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ctl_pull(ctl_pull),
  .ctl_xfer(ctl_xfer), .data_wr(data_wr), .st(st), .err(err),
  .data_strobe(data_strobe), .cfg_req_n(cfg_req_n), .chip_en_n(chip_en_n),
  .power_good(power_good), .mode_rd(mode_rd)
);

// File: tb/tb_cfg_seq_ctrl.sv
`timescale 1ns/1ps
module tb_cfg_seq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [1:0]  bus_raddr = 2'd0;
  logic [31:0] bus_rdata;
  logic [4:0]  msel_pins = 5'd0;
  logic        power_good = 1'b1;
  logic        fab_done = 1'b0;
  logic        fab_status = 1'b1;
  logic        cfg_req_n, chip_en_n, wide_bus, data_strobe;
  logic [1:0]  clk_ratio;
  logic [31:0] data_word;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cfg_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .msel_pins(msel_pins), .power_good(power_good), .fab_done(fab_done),
    .fab_status(fab_status), .cfg_req_n(cfg_req_n), .chip_en_n(chip_en_n),
    .clk_ratio(clk_ratio), .wide_bus(wide_bus), .data_word(data_word),
    .data_strobe(data_strobe)
  );

  localparam logic [31:0] EN = 32'h1, NCE = 32'h2, PULL = 32'h4,
                          XFER = 32'h100, WIDE = 32'h200;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_raddr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_pins(input int m);
    int v, r, w;
    v = (m < 16) && (m % 4 != 3);
    w = v && (m >= 8);
    r = 0;
    if (v && m % 4 == 1) r = w ? 2 : 1;
    if (v && m % 4 == 2) r = w ? 3 : 2;
    return (32'(w) << 12) | (32'(r) << 10) | (32'(!v) << 8) | (32'(m) << 3);
  endfunction

  task automatic mode_is(input string req, input int exp);
    logic [31:0] s;
    rd(2'd1, s);
    chk(req, {29'd0, s[2:0]}, 32'(exp));
  endtask

  initial begin
    logic [31:0] v;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h2);
    rd(2'd1, v); chk("R1 phase/err", v & 32'h207, 32'h0);
    chk("R1 outputs", {29'd0, cfg_req_n, chip_en_n, data_strobe}, 32'b110);

    // R10 disabled: pull ignored, data dropped
    wr(2'd0, NCE | PULL | XFER);
    chk("R10 req_n", {31'd0, cfg_req_n}, 32'd1);
    chk("R10 ce_n", {31'd0, chip_en_n}, 32'd1);
    step(1);
    mode_is("R10 phase unchanged", 0);
    wr(2'd2, 32'h1234_5678);
    chk("R10 no strobe", {31'd0, data_strobe}, 32'd0);

    // R12 control fields
    wr(2'd0, 32'hFFFF_FC38 | EN | 32'h80 | WIDE);
    rd(2'd0, v); chk("R12 kept bits", v, 32'h281);
    chk("R12 outputs", {28'd0, chip_en_n, clk_ratio, wide_bus}, 32'b0101);

    // R2 pull-low, R3 release
    wr(2'd0, EN | PULL | 32'h80 | WIDE);
    chk("R2 req_n low", {31'd0, cfg_req_n}, 32'd0);
    mode_is("R2 not yet", 0);
    step(1);
    mode_is("R2 reset phase", 1);
    wr(2'd0, EN | 32'h80 | WIDE);
    step(1);
    mode_is("R3 config phase", 2);

    // R8, R9 data forwarding
    wr(2'd0, EN | XFER | WIDE);
    wr(2'd2, 32'hDEAD_BEEF);
    chk("R8 strobe", {31'd0, data_strobe}, 32'd1);
    chk("R9 wide word", data_word, 32'hDEAD_BEEF);
    step(1);
    chk("R8 single strobe", {31'd0, data_strobe}, 32'd0);
    wr(2'd0, EN | XFER);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] w;
      w = 32'hA5C3_0F10 ^ (32'h1111_1111 * i);
      wr(2'd2, w);
      chk("R8 strobe narrow", {31'd0, data_strobe}, 32'd1);
      chk("R9 narrow word", data_word, w & 32'h0000_FFFF);
    end
    wr(2'd0, EN);
    wr(2'd2, 32'h5555_AAAA);
    chk("R8 no transfer", {31'd0, data_strobe}, 32'd0);
    mode_is("R8 phase kept", 2);

    // R4 success and trailing cycles
    fab_done = 1'b1;
    step(1);
    mode_is("R4 init phase", 3);
    step(3);
    mode_is("R4 still init", 3);
    step(1);
    mode_is("R4 user phase", 4);
    fab_done = 1'b0;
    step(2);
    mode_is("R4 user held", 4);

    // R11 power good
    power_good = 1'b0;
    mode_is("R11 reads zero", 0);
    step(2);
    power_good = 1'b1;
    mode_is("R11 restored", 4);

    // R5 failure path
    wr(2'd0, EN | PULL);
    step(1);
    wr(2'd0, EN);
    step(1);
    mode_is("R5 config again", 2);
    fab_status = 1'b0;
    step(1);
    rd(2'd1, v);
    chk("R5 fail to reset+err", v & 32'h207, 32'h201);
    fab_status = 1'b1;
    step(3);
    rd(2'd1, v);
    chk("R5 held in reset", v & 32'h207, 32'h201);
    wr(2'd0, EN | PULL);
    step(1);
    rd(2'd1, v);
    chk("R5 error cleared", v & 32'h207, 32'h001);
    wr(2'd0, EN);
    step(1);
    mode_is("R5 released", 2);

    // R6, R7 mode-select sweep
    for (int m = 0; m < 32; m++) begin
      msel_pins = 5'(m);
      step(1);
      rd(2'd1, v);
      chk("R6 R7 pins decode", v & 32'h1FF8, exp_pins(m));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule